// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fourteen interrupt causes for a processor core and reports the most urgent one as a vector number. The causes are ten active-low pins from outside the chip, two on-chip event lines (such as a timer tick or a counter overflow) and two bits that software sets and clears. A separate active-low non-maskable pin is reported both as a status bit and as a single-cycle pulse. The core reads a 16-bit cause register, programs a 14-bit enable mask and a global enable, and takes the request flag and vector from the outputs.

The external pins and the non-maskable pin pass through a two-stage synchronizer. After that they are folded into the cause register, with one bit for each pin. The pins are level-sensitive, so a cause bit stays set while its pin stays low and clears when the pin returns high. A legacy compatibility input moves the non-maskable status from bit 15 to bit 6. In that mode it shares bit 6 with external line 6 and is resolved as an ordinary maskable cause. Priority is fixed: the highest pending, enabled index wins, and the vector is that index. No interface carries streamed data. All pins are plain level or strobe controls, so no back-pressure rules apply.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held and at the first sample after it is released, `irq_o`, `nmi_pulse_o`, `gie_o`, `vec_o`, `mask_o` and `int_reg_o` are all zero.
- R2: When external pin `ext_irq_ni[i]` is driven low, cause bit i (for i in 0..9) reads 1 after three rising clock edges and not after two. The bit returns to 0 three edges after the pin goes high again.
- R3: Each on-chip line `int_src_i[j]` is copied into cause bit 10+j on the next rising edge and follows the line's level.
- R4: A pulse on `sw_set_i[k]` sets cause bit 12+k, and a pulse on `sw_clr_i[k]` clears it, each on the next edge. When both are high on the same edge, the set wins. The bit holds its value otherwise.
- R5: The synchronized, inverted non-maskable pin appears in cause bit 15 when `compat_mode_i` is 0. When `compat_mode_i` is 1 it is ORed into bit 6 and bit 15 reads 0. Bit 14 always reads 0.
- R6: `irq_o` is 1 exactly when `gie_o` is 1 and at least one of cause bits 13..0 is set together with the matching `mask_o` bit (mask bit = 1 means enabled).
- R7: When `irq_o` is 1, `vec_o` equals the highest index i in 0..13 whose cause bit and mask bit are both 1. When `irq_o` is 0, `vec_o` is 0.
- R8: A falling edge on `nmi_ni` produces exactly one cycle of `nmi_pulse_o`, visible after the third rising edge, whatever the mask, the global enable or the compatibility mode.
- R9: `mask_we_i` loads `mask_wdata_i` and `gie_we_i` loads `gie_wdata_i`, each on the next rising edge. Both values are held while their strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_irq_ni | input | 10 | External interrupt pins, active low |
| int_src_i | input | 2 | On-chip interrupt lines, active high |
| nmi_ni | input | 1 | Non-maskable interrupt pin, active low |
| compat_mode_i | input | 1 | 1 moves the non-maskable status to cause bit 6 |
| sw_set_i | input | 2 | Set strobes for the software cause bits |
| sw_clr_i | input | 2 | Clear strobes for the software cause bits |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 14 | New mask value |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_wdata_i | input | 1 | New global enable value |
| int_reg_o | output | 16 | Cause register as seen by software |
| mask_o | output | 14 | Current mask |
| gie_o | output | 1 | Current global enable |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 4 | Index of the winning cause |
| nmi_pulse_o | output | 1 | One-cycle non-maskable event |

## Verification
The bench probes the synchronizer depth by sampling one edge too early. If a stage were missing or added, the cause bit would appear a cycle early or late. It places several causes at once and then masks the top one to confirm that the next index wins. A reversed or broken encoder would report the wrong vector. It also runs the non-maskable pin in both mapping modes. A wrong mux would show the status in the wrong bit or let it bypass the mask in compatibility mode. Finally it raises the pulse with every mask and enable cleared and checks that it lasts one cycle. A level-instead-of-edge design would hold the pulse high, and a gated one would drop it entirely.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned N_EXT       = 10;
  localparam int unsigned N_ONCHIP    = 2;
  localparam int unsigned N_SOFT      = 2;
  localparam int unsigned N_SRC       = N_EXT + N_ONCHIP + N_SOFT;
  localparam int unsigned CAUSE_W     = 16;
  localparam int unsigned NMI_POS     = 15;
  localparam int unsigned NMI_ALT_POS = 6;
  localparam int unsigned VEC_W       = $clog2(N_SRC);
endpackage

// File: rtl/irq_prio_sync.sv
module irq_prio_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= {W{RST_VAL}};
      else if (s == 0) stg[s] <= d_i;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_prio_edge.sv
module irq_prio_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_d <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      level_d <= level_i;
      pulse_o <= level_i & ~level_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 14,
  parameter int unsigned VW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [VW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) idx_o = VW'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_EXT-1:0]     ext_irq_ni,
  input  logic [N_ONCHIP-1:0]  int_src_i,
  input  logic                 nmi_ni,
  input  logic                 compat_mode_i,
  input  logic [N_SOFT-1:0]    sw_set_i,
  input  logic [N_SOFT-1:0]    sw_clr_i,
  input  logic                 mask_we_i,
  input  logic [N_SRC-1:0]     mask_wdata_i,
  input  logic                 gie_we_i,
  input  logic                 gie_wdata_i,
  output logic [CAUSE_W-1:0]   int_reg_o,
  output logic [N_SRC-1:0]     mask_o,
  output logic                 gie_o,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 nmi_pulse_o
);
  localparam int unsigned HW_W = N_EXT + N_ONCHIP;

  logic [N_EXT-1:0]  ext_sync_n;
  logic              nmi_sync_n;
  logic [HW_W-1:0]   hw_q;
  logic              nmi_lvl_q;
  logic [N_SOFT-1:0] soft_q;
  logic [N_SRC-1:0]  mask_q;
  logic              gie_q;
  logic [N_SRC-1:0]  pend;
  logic              any_pend;
  logic [VEC_W-1:0]  win_idx;

  irq_prio_sync #(.W(N_EXT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_irq_ni), .q_o(ext_sync_n)
  );

  irq_prio_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nmi_ni), .q_o(nmi_sync_n)
  );

  irq_prio_edge u_nmi_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(~nmi_sync_n), .pulse_o(nmi_pulse_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q      <= '0;
      nmi_lvl_q <= 1'b0;
      mask_q    <= '0;
      gie_q     <= 1'b0;
    end else begin
      hw_q      <= {int_src_i, ~ext_sync_n};
      nmi_lvl_q <= ~nmi_sync_n;
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (gie_we_i)  gie_q  <= gie_wdata_i;
    end
  end

  for (genvar k = 0; k < N_SOFT; k++) begin : g_soft
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          soft_q[k] <= 1'b0;
      else if (sw_set_i[k]) soft_q[k] <= 1'b1;
      else if (sw_clr_i[k]) soft_q[k] <= 1'b0;
    end
  end

  always_comb begin
    int_reg_o = '0;
    int_reg_o[HW_W-1:0]     = hw_q;
    int_reg_o[N_SRC-1:HW_W] = soft_q;
    if (compat_mode_i) int_reg_o[NMI_ALT_POS] = hw_q[NMI_ALT_POS] | nmi_lvl_q;
    else               int_reg_o[NMI_POS]     = nmi_lvl_q;
  end

  assign pend = int_reg_o[N_SRC-1:0] & mask_q;

  irq_prio_enc #(.N(N_SRC), .VW(VEC_W)) u_enc (
    .pend_i(pend), .any_o(any_pend), .idx_o(win_idx)
  );

  assign irq_o  = gie_q & any_pend;
  assign vec_o  = irq_o ? win_idx : '0;
  assign mask_o = mask_q;
  assign gie_o  = gie_q;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  int_src_i,
  input logic        compat_mode_i,
  input logic [1:0]  sw_set_i,
  input logic [15:0] int_reg_o,
  input logic [13:0] mask_o,
  input logic        gie_o,
  input logic        irq_o,
  input logic [3:0]  vec_o,
  input logic        nmi_pulse_o
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_o); // R6
  AST_VEC_IS_ENABLED_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_o[vec_o] && int_reg_o[vec_o])); // R7
  AST_VEC_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_o == 4'd0)); // R7
  AST_NMI_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pulse_o |=> !nmi_pulse_o); // R8
  AST_BIT14_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_reg_o[14] == 1'b0); // R5
  AST_COMPAT_HIDES_BIT15: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compat_mode_i |-> !int_reg_o[15]); // R5
  AST_SOFT_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_set_i[0] |=> int_reg_o[12]); // R4
  AST_ONCHIP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (int_reg_o[11:10] == $past(int_src_i))); // R3
endmodule

bind irq_prio_ctrl irq_prio_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_src_i(int_src_i),
  .compat_mode_i(compat_mode_i), .sw_set_i(sw_set_i), .int_reg_o(int_reg_o),
  .mask_o(mask_o), .gie_o(gie_o), .irq_o(irq_o), .vec_o(vec_o),
  .nmi_pulse_o(nmi_pulse_o)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  ext_irq_ni = '1;
  logic [1:0]  int_src_i = '0;
  logic        nmi_ni = 1'b1;
  logic        compat_mode_i = 1'b0;
  logic [1:0]  sw_set_i = '0;
  logic [1:0]  sw_clr_i = '0;
  logic        mask_we_i = 1'b0;
  logic [13:0] mask_wdata_i = '0;
  logic        gie_we_i = 1'b0;
  logic        gie_wdata_i = 1'b0;
  logic [15:0] int_reg_o;
  logic [13:0] mask_o;
  logic        gie_o;
  logic        irq_o;
  logic [3:0]  vec_o;
  logic        nmi_pulse_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_prio_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic write_mask(input logic [13:0] m);
    mask_we_i = 1'b1; mask_wdata_i = m; step(1); mask_we_i = 1'b0;
  endtask

  task automatic write_gie(input logic g);
    gie_we_i = 1'b1; gie_wdata_i = g; step(1); gie_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(irq_o == 0 && nmi_pulse_o == 0 && gie_o == 0, "R1", {irq_o, nmi_pulse_o, gie_o}, 0);
    chk(int_reg_o == 0 && mask_o == 0 && vec_o == 0, "R1", int_reg_o, 0);
  endtask

  task automatic t_registers();
    write_mask(14'h2A55);
    chk(mask_o == 14'h2A55, "R9", mask_o, 14'h2A55);
    mask_wdata_i = 14'h0001; step(2);
    chk(mask_o == 14'h2A55, "R9", mask_o, 14'h2A55);
    write_gie(1'b1);
    chk(gie_o == 1'b1, "R9", gie_o, 1);
    write_gie(1'b0);
    write_mask(14'h0000);
  endtask

  task automatic t_ext_lines();
    ext_irq_ni[4] = 1'b0;
    step(2);
    chk(int_reg_o[4] == 1'b0, "R2", int_reg_o[4], 0);
    step(1);
    chk(int_reg_o[4] == 1'b1, "R2", int_reg_o[4], 1);
    ext_irq_ni[4] = 1'b1;
    step(3);
    chk(int_reg_o[4] == 1'b0, "R2", int_reg_o[4], 0);
    ext_irq_ni = 10'b0111111110;
    step(3);
    chk(int_reg_o[9:0] == 10'b1000000001, "R2", int_reg_o[9:0], 10'b1000000001);
    ext_irq_ni = '1;
    step(3);
  endtask

  task automatic t_onchip();
    int_src_i = 2'b10;
    step(1);
    chk(int_reg_o[11:10] == 2'b10, "R3", int_reg_o[11:10], 2);
    int_src_i = 2'b01;
    step(1);
    chk(int_reg_o[11:10] == 2'b01, "R3", int_reg_o[11:10], 1);
    int_src_i = 2'b00;
    step(1);
  endtask

  task automatic t_software();
    sw_set_i = 2'b11; step(1); sw_set_i = 2'b00;
    chk(int_reg_o[13:12] == 2'b11, "R4", int_reg_o[13:12], 3);
    step(2);
    chk(int_reg_o[13:12] == 2'b11, "R4", int_reg_o[13:12], 3);
    sw_clr_i = 2'b01; step(1); sw_clr_i = 2'b00;
    chk(int_reg_o[13:12] == 2'b10, "R4", int_reg_o[13:12], 2);
    sw_set_i = 2'b01; sw_clr_i = 2'b01; step(1); sw_set_i = '0; sw_clr_i = '0;
    chk(int_reg_o[12] == 1'b1, "R4 set wins", int_reg_o[12], 1);
    sw_clr_i = 2'b11; step(1); sw_clr_i = '0;
    chk(int_reg_o[13:12] == 2'b00, "R4", int_reg_o[13:12], 0);
  endtask

  task automatic t_priority();
    write_mask(14'h3FFF);
    write_gie(1'b1);
    ext_irq_ni[3] = 1'b0; ext_irq_ni[9] = 1'b0; int_src_i = 2'b10;
    step(3);
    chk(irq_o == 1 && vec_o == 4'd11, "R7", vec_o, 11);
    write_mask(14'h37FF);
    chk(irq_o == 1 && vec_o == 4'd9, "R7", vec_o, 9);
    sw_set_i = 2'b10; step(1); sw_set_i = '0;
    chk(vec_o == 4'd13, "R7", vec_o, 13);
    write_mask(14'h0008);
    chk(irq_o == 1 && vec_o == 4'd3, "R7", vec_o, 3);
    write_mask(14'h0004);
    chk(irq_o == 0 && vec_o == 0, "R6 masked", {irq_o, vec_o}, 0);
    write_mask(14'h3FFF);
    write_gie(1'b0);
    chk(irq_o == 0 && vec_o == 0, "R6 gie off", {irq_o, vec_o}, 0);
    ext_irq_ni = '1; int_src_i = '0; sw_clr_i = 2'b11; step(1); sw_clr_i = '0;
    step(3);
    write_gie(1'b1);
    chk(irq_o == 0, "R6 nothing pending", irq_o, 0);
    write_gie(1'b0);
    write_mask(14'h0000);
  endtask

  task automatic t_nmi();
    compat_mode_i = 1'b0;
    nmi_ni = 1'b0;
    step(2);
    chk(nmi_pulse_o == 0, "R8 early", nmi_pulse_o, 0);
    step(1);
    chk(nmi_pulse_o == 1, "R8 pulse", nmi_pulse_o, 1);
    chk(int_reg_o[15] == 1 && int_reg_o[6] == 0, "R5 normal map", int_reg_o, 16'h8000);
    step(1);
    chk(nmi_pulse_o == 0, "R8 one cycle", nmi_pulse_o, 0);
    compat_mode_i = 1'b1;
    write_mask(14'h0040);
    write_gie(1'b1);
    chk(int_reg_o[6] == 1 && int_reg_o[15] == 0 && int_reg_o[14] == 0, "R5 compat map", int_reg_o, 16'h0040);
    chk(irq_o == 1 && vec_o == 4'd6, "R5 compat source", vec_o, 6);
    chk(nmi_pulse_o == 0, "R8 level holds no pulse", nmi_pulse_o, 0);
    nmi_ni = 1'b1;
    step(3);
    chk(int_reg_o == 16'h0000 && irq_o == 0, "R5 release", int_reg_o, 0);
    compat_mode_i = 1'b0;
    write_gie(1'b0);
    write_mask(14'h0000);
  endtask

  task automatic t_nmi_bypass();
    compat_mode_i = 1'b1;
    nmi_ni = 1'b0;
    step(3);
    chk(nmi_pulse_o == 1 && irq_o == 0, "R8 bypass", {nmi_pulse_o, irq_o}, 2);
    nmi_ni = 1'b1;
    step(4);
    compat_mode_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1);
    t_reset();
    step(2);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_registers();
    t_ext_lines();
    t_onchip();
    t_software();
    t_priority();
    t_nmi();
    t_nmi_bypass();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule